// File: doc/BRIEF.md
# PLL Mode and Reset Sequencer

This controller walks a clock synthesizer from power-up to locked operation and back through reconfiguration. It runs on the input reference clock. It keeps the synthesizer in bypass, where the reference passes straight through, until three intervals have been timed in order. The first lets the regulators settle after power-up. The second holds the synthesizer in reset. The third, after reset is released and still in bypass, lets the loop lock. Only then does it select the multiplied path.

A host programs the pre-divider and multiplier values and issues a start command. While any frequency change is in progress, the block raises a hold-off output that fences off outside accesses. When the change is finished, the hold-off drops and a one-cycle completion interrupt fires in the same cycle.

The intervals are given in time units and turned into reference-clock cycles at elaboration, rounding up. The synthesizer itself, the glitch-free clock switch and any lock detector are outside this block.

Top module: `pll_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs are `pll_enable`=0, `pll_reset`=0, `host_hold`=1 and `done_irq`=0, with `prediv_out`=PREDIV_INIT and `mult_out`=MULT_INIT.
- R2: After reset release, `host_hold` stays 1 for exactly STAB_CYC cycles with `pll_reset` and `pll_enable` both 0. It then falls, and the block waits idle in bypass. STAB_CYC = ceil(STAB_TIME_NS*1000 / CLK_PERIOD_PS), which is 20000 with the defaults.
- R3: A one-cycle `reconfig_req` in idle bypass raises `pll_reset` from the next cycle for exactly RST_CYC = ceil(RESET_TIME_NS*1000 / CLK_PERIOD_PS) cycles (200 with the defaults). `pll_enable` stays 0 throughout.
- R4: After `pll_reset` falls, `pll_enable` stays 0 and `pll_reset` stays 0 for exactly LOCK_PERIODS cycles (2000 with the defaults). `pll_enable` then rises and stays 1.
- R5: `host_hold` is 1 from the cycle after an accepted `reconfig_req` until `pll_enable` rises. It falls in that same cycle. `done_irq` is 1 for exactly one cycle, on each cycle where `host_hold` falls.
- R6: A `reconfig_req` while `pll_enable` is 1 drops `pll_enable` the next cycle. It then spends one cycle in bypass with `pll_reset`=0 and `host_hold`=1, and then runs the R3 and R4 sequence again.
- R7: A write strobe (`prediv_wr`, `mult_wr`) updates its output on the next cycle only while the block is in bypass and not in the lock wait. That covers power-up wait, idle, the bypass-return cycle and reset assertion. In lock wait and in PLL mode the write is ignored.
- R8: `reconfig_req` is ignored during power-up wait, reset assertion and lock wait: the interval lengths are unchanged.
- R9: `pll_reset` and `pll_enable` are never 1 in the same cycle.
- R10: Cycle counts round up. With CLK_PERIOD_PS=3000, STAB_TIME_NS=1000, RESET_TIME_NS=100 and LOCK_PERIODS=50, the intervals are 334, 34 and 50 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reconfig_req | input | 1 | Start (re)configuration command, one-cycle pulse |
| prediv_wr | input | 1 | Pre-divider write strobe |
| prediv_wdata | input | PREDIV_W | Pre-divider write value |
| mult_wr | input | 1 | Multiplier write strobe |
| mult_wdata | input | MULT_W | Multiplier write value |
| pll_reset | output | 1 | Reset to the synthesizer, active high |
| pll_enable | output | 1 | Mode select: 0 bypass, 1 multiplied path |
| prediv_out | output | PREDIV_W | Pre-divider value applied to the synthesizer |
| mult_out | output | MULT_W | Multiplier value applied to the synthesizer |
| host_hold | output | 1 | Hold off outside accesses |
| done_irq | output | 1 | One-cycle completion interrupt |

## Verification
The hardest situation to reach is a command or a register write that lands in the middle of a timed interval. It must leave the interval length untouched, and the write must be accepted during reset assertion but refused during the lock wait. The bench pulses `reconfig_req` and both write strobes a few cycles into the reset phase and again a few cycles into the lock wait. It does this while counting every cycle of each phase, and then checks both the exact phase lengths and which values reached the outputs. A second instance with an odd clock period, where no interval divides evenly, shows the rounding.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    ST_POWERUP = 3'd0,
    ST_IDLE    = 3'd1,
    ST_SWITCH  = 3'd2,
    ST_RESET   = 3'd3,
    ST_LOCK    = 3'd4,
    ST_PLL     = 3'd5
  } seq_state_t;

  // ceil(duration / period), never below one cycle
  function automatic int unsigned ps_to_cycles(input longint unsigned dur_ps,
                                               input longint unsigned per_ps);
    longint unsigned q;
    q = (dur_ps + per_ps - 64'd1) / per_ps;
    if (q == 64'd0) q = 64'd1;
    return 32'(q);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned maxv);
    int unsigned w;
    w = 32'($clog2(longint'(maxv) + 1));
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned INIT_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= CNT_W'(INIT_VAL);
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R2
  timer_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/pll_seq_cfg.sv
module pll_seq_cfg #(
  parameter int unsigned PREDIV_W    = 6,
  parameter int unsigned MULT_W      = 8,
  parameter int unsigned PREDIV_INIT = 1,
  parameter int unsigned MULT_INIT   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ok,
  input  logic                prediv_wr,
  input  logic [PREDIV_W-1:0] prediv_wdata,
  input  logic                mult_wr,
  input  logic [MULT_W-1:0]   mult_wdata,
  output logic [PREDIV_W-1:0] prediv_q,
  output logic [MULT_W-1:0]   mult_q
);

  logic take_prediv, take_mult;
  assign take_prediv = wr_ok && prediv_wr;
  assign take_mult   = wr_ok && mult_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prediv_q <= PREDIV_W'(PREDIV_INIT);
      mult_q   <= MULT_W'(MULT_INIT);
    end else begin
      if (take_prediv) prediv_q <= prediv_wdata;
      if (take_mult)   mult_q   <= mult_wdata;
    end
  end

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> ($stable(prediv_q) && $stable(mult_q)));

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm import pll_seq_pkg::*; #(
  parameter int unsigned STAB_CYC = 20000,
  parameter int unsigned RST_CYC  = 200,
  parameter int unsigned LOCK_CYC = 2000,
  parameter int unsigned CNT_W    = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reconfig_req,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_load_val,
  output logic             cfg_wr_ok,
  output logic             pll_reset,
  output logic             pll_enable,
  output logic             host_hold,
  output logic             done_irq
);

  seq_state_t state_q, state_d;
  logic       enter_pll, enter_idle;

  // cycles spent in a state, minus one, as loaded into the timer
  function automatic logic [CNT_W-1:0] dwell_of(input seq_state_t s);
    case (s)
      ST_POWERUP: return CNT_W'(STAB_CYC - 1);
      ST_RESET:   return CNT_W'(RST_CYC - 1);
      ST_LOCK:    return CNT_W'(LOCK_CYC - 1);
      default:    return '0;
    endcase
  endfunction

  function automatic logic holds_host(input seq_state_t s);
    return (s == ST_POWERUP) || (s == ST_SWITCH) || (s == ST_RESET) || (s == ST_LOCK);
  endfunction

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_POWERUP: if (tmr_zero)     state_d = ST_IDLE;
      ST_IDLE:    if (reconfig_req) state_d = ST_RESET;
      ST_RESET:   if (tmr_zero)     state_d = ST_LOCK;
      ST_LOCK:    if (tmr_zero)     state_d = ST_PLL;
      ST_PLL:     if (reconfig_req) state_d = ST_SWITCH;
      ST_SWITCH:                    state_d = ST_RESET;
      default:                      state_d = ST_POWERUP;
    endcase
  end

  assign tmr_load     = (state_d != state_q);
  assign tmr_load_val = dwell_of(state_d);
  assign enter_pll    = tmr_load && (state_d == ST_PLL);
  assign enter_idle   = tmr_load && (state_d == ST_IDLE);
  assign cfg_wr_ok    = (state_q == ST_POWERUP) || (state_q == ST_IDLE) ||
                        (state_q == ST_SWITCH)  || (state_q == ST_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_POWERUP;
      pll_reset  <= 1'b0;
      pll_enable <= 1'b0;
      host_hold  <= 1'b1;
      done_irq   <= 1'b0;
    end else begin
      state_q    <= state_d;
      pll_reset  <= (state_d == ST_RESET);
      pll_enable <= (state_d == ST_PLL);
      host_hold  <= holds_host(state_d);
      done_irq   <= enter_pll || enter_idle;
    end
  end

  // R9
  excl_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pll_reset && pll_enable));

  // R4
  lock_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_enable) |-> ($past(!pll_reset) && $past(host_hold)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R5
  hold_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_hold) |-> done_irq);

  // R5
  done_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !host_hold);

  // R3
  reset_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_reset && !tmr_zero) |=> pll_reset);

  // R6
  switch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_enable) |-> (!pll_reset && host_hold));

  // R6
  switch_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_enable) |=> pll_reset);

  // R8
  lock_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && !tmr_zero) |=> (state_q == ST_LOCK));

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl import pll_seq_pkg::*; #(
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned STAB_TIME_NS  = 100000,
  parameter int unsigned RESET_TIME_NS = 1000,
  parameter int unsigned LOCK_PERIODS  = 2000,
  parameter int unsigned PREDIV_W      = 6,
  parameter int unsigned MULT_W        = 8,
  parameter int unsigned PREDIV_INIT   = 1,
  parameter int unsigned MULT_INIT     = 10
) (
  input  logic                clk_in,
  input  logic                rst_n,
  input  logic                reconfig_req,
  input  logic                prediv_wr,
  input  logic [PREDIV_W-1:0] prediv_wdata,
  input  logic                mult_wr,
  input  logic [MULT_W-1:0]   mult_wdata,
  output logic                pll_reset,
  output logic                pll_enable,
  output logic [PREDIV_W-1:0] prediv_out,
  output logic [MULT_W-1:0]   mult_out,
  output logic                host_hold,
  output logic                done_irq
);

  localparam int unsigned STAB_CYC = ps_to_cycles(longint'(STAB_TIME_NS) * 1000, CLK_PERIOD_PS);
  localparam int unsigned RST_CYC  = ps_to_cycles(longint'(RESET_TIME_NS) * 1000, CLK_PERIOD_PS);
  localparam int unsigned LOCK_CYC = (LOCK_PERIODS < 1) ? 1 : LOCK_PERIODS;
  localparam int unsigned CNT_W    = cnt_width(max3(STAB_CYC, RST_CYC, LOCK_CYC));

  logic             tmr_zero;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_load_val;
  logic             cfg_wr_ok;

  pll_seq_timer #(
    .CNT_W    (CNT_W),
    .INIT_VAL (STAB_CYC - 1)
  ) u_timer (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_load_val),
    .zero     (tmr_zero)
  );

  pll_seq_fsm #(
    .STAB_CYC (STAB_CYC),
    .RST_CYC  (RST_CYC),
    .LOCK_CYC (LOCK_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk          (clk_in),
    .rst_n        (rst_n),
    .reconfig_req (reconfig_req),
    .tmr_zero     (tmr_zero),
    .tmr_load     (tmr_load),
    .tmr_load_val (tmr_load_val),
    .cfg_wr_ok    (cfg_wr_ok),
    .pll_reset    (pll_reset),
    .pll_enable   (pll_enable),
    .host_hold    (host_hold),
    .done_irq     (done_irq)
  );

  pll_seq_cfg #(
    .PREDIV_W    (PREDIV_W),
    .MULT_W      (MULT_W),
    .PREDIV_INIT (PREDIV_INIT),
    .MULT_INIT   (MULT_INIT)
  ) u_cfg (
    .clk          (clk_in),
    .rst_n        (rst_n),
    .wr_ok        (cfg_wr_ok),
    .prediv_wr    (prediv_wr),
    .prediv_wdata (prediv_wdata),
    .mult_wr      (mult_wr),
    .mult_wdata   (mult_wdata),
    .prediv_q     (prediv_out),
    .mult_q       (mult_out)
  );

endmodule

// File: tb/pll_seq_ctrl_tb.sv
module pll_seq_ctrl_tb;

  localparam int CAP = 40000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst1_n = 1'b0, rst2_n = 1'b0;
  logic req1 = 1'b0, req2 = 1'b0;
  logic pwr = 1'b0, mwr = 1'b0;
  logic [5:0] pdata = '0;
  logic [7:0] mdata = '0;

  logic r1, e1, h1, d1, r2, e2, h2, d2;
  logic [5:0] p1, p2;
  logic [7:0] m1, m2;

  pll_seq_ctrl u_dut (
    .clk_in(clk), .rst_n(rst1_n), .reconfig_req(req1),
    .prediv_wr(pwr), .prediv_wdata(pdata), .mult_wr(mwr), .mult_wdata(mdata),
    .pll_reset(r1), .pll_enable(e1), .prediv_out(p1), .mult_out(m1),
    .host_hold(h1), .done_irq(d1));

  pll_seq_ctrl #(.CLK_PERIOD_PS(3000), .STAB_TIME_NS(1000), .RESET_TIME_NS(100),
                 .LOCK_PERIODS(50)) u_dut_odd (
    .clk_in(clk), .rst_n(rst2_n), .reconfig_req(req2),
    .prediv_wr(1'b0), .prediv_wdata(6'd0), .mult_wr(1'b0), .mult_wdata(8'd0),
    .pll_reset(r2), .pll_enable(e2), .prediv_out(p2), .mult_out(m2),
    .host_hold(h2), .done_irq(d2));

  logic sel = 1'b0;
  logic o_rst, o_en, o_hold, o_done;
  assign o_rst  = sel ? r2 : r1;
  assign o_en   = sel ? e2 : e1;
  assign o_hold = sel ? h2 : h1;
  assign o_done = sel ? d2 : d1;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_req(input logic v);
    if (sel) req2 = v; else req1 = v;
  endtask

  task automatic drive_wr(input logic w, input logic [5:0] pv, input logic [7:0] mv);
    pwr = w; mwr = w; pdata = pv; mdata = mv;
  endtask

  // R1: outputs while reset is held
  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    chk("R1 pll_enable", e1, 0);
    chk("R1 pll_reset", r1, 0);
    chk("R1 host_hold", h1, 1);
    chk("R1 done_irq", d1, 0);
    chk("R1 prediv_out", p1, 1);
    chk("R1 mult_out", m1, 10);
  endtask

  // R2, R8: power-up interval; a command mid-way must not start a sequence
  task automatic t_powerup(input int exp_stab, input bit inject);
    int n = 0;
    bit bad = 0;
    if (sel) rst2_n = 1'b1; else rst1_n = 1'b1;
    while (o_hold && n < CAP) begin
      if (o_rst || o_en) bad = 1;
      set_req(inject && n == 100);
      n++;
      @(negedge clk);
    end
    set_req(1'b0);
    chk("R2 power-up length", n, exp_stab);
    chk("R2 bypass kept during power-up", bad, 0);
    chk("R5 done at hold fall (power-up)", o_done, 1);
    @(negedge clk);
    chk("R5 done width (power-up)", o_done, 0);
    chk("R8 command in power-up ignored", o_rst, 0);
    chk("R2 idle hold low", o_hold, 0);
  endtask

  // R3, R4, R5, R7, R8: runs from the first cycle of reset assertion
  task automatic run_lock(input int exp_rst, input int exp_lock, input bit inject);
    int n = 0, m = 0;
    bit bad = 0;
    while (o_rst && n < CAP) begin
      if (o_en || !o_hold) bad = 1;
      drive_wr(inject && n == 3, 6'd5, 8'd40);
      set_req(inject && n == 3);
      n++;
      @(negedge clk);
    end
    drive_wr(1'b0, 6'd0, 8'd0);
    set_req(1'b0);
    chk("R3 reset length", n, exp_rst);
    chk("R3 bypass and hold during reset", bad, 0);
    while (!o_en && m < CAP) begin
      if (o_rst || !o_hold) bad = 1;
      drive_wr(inject && m == 3, 6'd9, 8'd99);
      set_req(inject && m == 3);
      m++;
      @(negedge clk);
    end
    drive_wr(1'b0, 6'd0, 8'd0);
    set_req(1'b0);
    chk("R4 lock wait length", m, exp_lock);
    chk("R4 reset low, hold high in lock wait", bad, 0);
    chk("R5 hold falls with enable", o_hold, 0);
    chk("R5 done at completion", o_done, 1);
    chk("R9 reset low in PLL mode", o_rst, 0);
    @(negedge clk);
    chk("R5 done one cycle", o_done, 0);
    chk("R4 enable stays", o_en, 1);
    if (inject) begin
      chk("R7 prediv write in reset taken", p1, 5);
      chk("R7 mult write in reset taken, lock-wait write ignored", m1, 40);
    end
  endtask

  task automatic t_start_from_idle(input int exp_rst, input int exp_lock, input bit inject);
    set_req(1'b1);
    @(negedge clk);
    set_req(1'b0);
    run_lock(exp_rst, exp_lock, inject);
  endtask

  // R7: writes while idle in bypass
  task automatic t_idle_write();
    drive_wr(1'b1, 6'd3, 8'd20);
    @(negedge clk);
    drive_wr(1'b0, 6'd0, 8'd0);
    chk("R7 idle prediv write", p1, 3);
    chk("R7 idle mult write", m1, 20);
  endtask

  // R7: writes in PLL mode have no effect
  task automatic t_pll_write();
    drive_wr(1'b1, 6'd11, 8'd77);
    @(negedge clk);
    drive_wr(1'b0, 6'd0, 8'd0);
    @(negedge clk);
    chk("R7 PLL-mode prediv write ignored", p1, 5);
    chk("R7 PLL-mode mult write ignored", m1, 40);
  endtask

  // R6: reconfigure from PLL mode
  task automatic t_from_pll(input int exp_rst, input int exp_lock);
    set_req(1'b1);
    @(negedge clk);
    set_req(1'b0);
    chk("R6 enable dropped", o_en, 0);
    chk("R6 bypass cycle reset low", o_rst, 0);
    chk("R6 bypass cycle hold high", o_hold, 1);
    @(negedge clk);
    chk("R6 reset follows bypass cycle", o_rst, 1);
    run_lock(exp_rst, exp_lock, 1'b0);
  endtask

  initial begin
    t_reset_state();
    @(negedge clk);
    t_powerup(20000, 1'b1);
    t_idle_write();
    t_start_from_idle(200, 2000, 1'b1);
    t_pll_write();
    t_from_pll(200, 2000);
    // R10: odd period, intervals round up
    sel = 1'b1;
    @(negedge clk);
    t_powerup(334, 1'b1);
    t_start_from_idle(34, 50, 1'b0);
    chk("R10 odd instance enabled", e2, 1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2..R10 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule